// File: doc/BRIEF.md
# Add-with-Carry ALU with Packed Status Flags

This unit holds an 8-bit accumulator and an 8-bit packed status register. On an add strobe it forms the sum of the accumulator, a memory operand and the stored carry. The low eight bits of that sum go back into the accumulator, and carry, signed overflow, zero and negative are updated together. On a load strobe the accumulator takes a new value, and only zero and negative follow that value.

The status register can also be changed one flag at a time. A selected bit can be set or cleared, and any selected bit can be read on a single test output. The whole byte can be written in one cycle and is always visible on an output, which covers saving the status to a stack and restoring it. The unit is meant to sit in the datapath of a small 8-bit processor core. The sequencing around it is left to that core.

Status bit positions, from bit 0 upward: carry (0), zero (1), interrupt mask (2), decimal (3), break (4), reserved (5, always 1), overflow (6), negative (7).

Top module: `adc_flag_unit`

## Requirements
- R1: A synchronous active-high reset clears the accumulator to 0x00 and sets the status byte to 0x20.
- R2: Status bit 5 reads as 1 in every cycle after reset, whatever was written, set or cleared.
- R3: With `add_en` high, the accumulator becomes the low 8 bits of accumulator + `operand` + status bit 0. Status bit 0 becomes bit 8 of that 9-bit sum.
- R4: On an add, status bit 6 is set exactly when the accumulator and `operand` share bit 7 and the result's bit 7 differs from the old accumulator's bit 7.
- R5: On an add or a load, status bit 1 is set when the new accumulator is 0x00, and status bit 7 equals bit 7 of the new accumulator.
- R6: With `ld_en` high and `add_en` low, the accumulator takes `ld_data`. Status bits 0, 2, 3, 4 and 6 keep their values.
- R7: When `add_en` and `ld_en` are both high, the add is performed and `ld_data` is ignored.
- R8: An add leaves status bits 2, 3 and 4 unchanged.
- R9: `flag_op` = 2'b01 sets and 2'b10 clears the status bit indexed by `flag_sel` (0 to 7, the bit positions above). The other seven bits are unchanged. The codes 00 and 11 do nothing. A set or clear takes precedence over the flag update of a same-cycle add or load, but the accumulator is still written.
- R10: With `st_wr_en` high, the status byte becomes `st_wr_data` with bit 5 forced to 1. This overrides every other status update in that cycle.
- R11: `flag_bit` always equals the current status bit indexed by `flag_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load accumulator strobe |
| ld_data | input | 8 | Value to load |
| add_en | input | 1 | Add-with-carry strobe |
| operand | input | 8 | Memory operand for the add |
| flag_op | input | 2 | 01 set, 10 clear, others none |
| flag_sel | input | 3 | Status bit index for set, clear and test |
| st_wr_en | input | 1 | Whole status byte write strobe |
| st_wr_data | input | 8 | Status byte to write |
| acc_out | output | 8 | Current accumulator |
| status_out | output | 8 | Current status byte |
| flag_bit | output | 1 | Status bit selected by flag_sel |

## Verification
The hardest case to reach from the ports is signed overflow alongside a known incoming carry. Before the add, the carry has to be placed deliberately while the load in between leaves it alone. The stimulus clears the status byte with a whole-byte write, loads the accumulator, optionally sets bit 0 with a single-flag set, and then adds. A table of sums that cross sign and carry boundaries uses this sequence, including 0x7F + 0x00 with carry in and 0x80 + 0x80. Same-cycle collisions are driven directly: add with load, set with add, and byte write with set.

// File: rtl/adc_flag_unit.sv
module adc_flag_unit (
  input  logic       clk,
  input  logic       rst,
  input  logic       ld_en,
  input  logic [7:0] ld_data,
  input  logic       add_en,
  input  logic [7:0] operand,
  input  logic [1:0] flag_op,
  input  logic [2:0] flag_sel,
  input  logic       st_wr_en,
  input  logic [7:0] st_wr_data,
  output logic [7:0] acc_out,
  output logic [7:0] status_out,
  output logic       flag_bit
);
  localparam int BC = 0, BZ = 1, BU = 5, BV = 6, BN = 7;
  localparam logic [7:0] ST_RESET = 8'h20;
  localparam logic [1:0] OP_SET = 2'b01, OP_CLR = 2'b10;

  logic [7:0] acc_q, st_q, st_nx, acc_nx;

  wire [8:0] sum     = {1'b0, acc_q} + {1'b0, operand} + {8'd0, st_q[BC]};
  wire [7:0] res     = sum[7:0];
  wire       ovf     = ~(acc_q[7] ^ operand[7]) & (acc_q[7] ^ res[7]);
  wire [7:0] sel_msk = 8'b1 << flag_sel;

  always_comb begin
    st_nx = st_q;
    if (st_wr_en)               st_nx = st_wr_data;
    else if (flag_op == OP_SET) st_nx = st_q | sel_msk;
    else if (flag_op == OP_CLR) st_nx = st_q & ~sel_msk;
    else if (add_en)            st_nx = {res[7], ovf, st_q[5:2], res == 8'd0, sum[8]};
    else if (ld_en)             st_nx = {ld_data[7], st_q[6:2], ld_data == 8'd0, st_q[BC]};
    st_nx[BU] = 1'b1;
  end

  assign acc_nx = add_en ? res : (ld_en ? ld_data : acc_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= 8'd0;
      st_q  <= ST_RESET;
    end else begin
      acc_q <= acc_nx;
      st_q  <= st_nx;
    end
  end

  assign acc_out    = acc_q;
  assign status_out = st_q;
  assign flag_bit   = st_q[flag_sel];

  wire quiet_st = !st_wr_en && flag_op != OP_SET && flag_op != OP_CLR;

  a_r2_reserved_one: assert property (@(posedge clk) disable iff (rst)
    status_out[BU] == 1'b1);

  a_r3_carry_sum: assert property (@(posedge clk) disable iff (rst)
    add_en && quiet_st |=> {status_out[BC], acc_out} ==
      {1'b0, $past(acc_out)} + {1'b0, $past(operand)} + {8'd0, $past(status_out[BC])});

  a_r4_overflow: assert property (@(posedge clk) disable iff (rst)
    add_en && quiet_st |=> status_out[BV] ==
      (($past(acc_out[7]) == $past(operand[7])) && (acc_out[7] != $past(acc_out[7]))));

  a_r5_zero_neg: assert property (@(posedge clk) disable iff (rst)
    (add_en || ld_en) && quiet_st |=>
      status_out[BZ] == (acc_out == 8'd0) && status_out[BN] == acc_out[7]);

  a_r6_load_keeps: assert property (@(posedge clk) disable iff (rst)
    ld_en && !add_en && quiet_st |=> acc_out == $past(ld_data) &&
      status_out[6:2] == $past(status_out[6:2]) && status_out[BC] == $past(status_out[BC]));

  a_r8_add_keeps: assert property (@(posedge clk) disable iff (rst)
    add_en && quiet_st |=> status_out[4:2] == $past(status_out[4:2]));

  a_r9_others_untouched: assert property (@(posedge clk) disable iff (rst)
    !st_wr_en && (flag_op == OP_SET || flag_op == OP_CLR) |=>
      ((status_out ^ $past(status_out)) & ~$past(sel_msk) & ~ST_RESET) == 8'd0);

  a_r10_byte_write: assert property (@(posedge clk) disable iff (rst)
    st_wr_en |=> status_out == ($past(st_wr_data) | ST_RESET));
endmodule

// File: tb/tb_adc_flag_unit.sv
module tb_adc_flag_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_en = 1'b0, add_en = 1'b0, st_wr_en = 1'b0;
  logic [7:0] ld_data = '0, operand = '0, st_wr_data = '0;
  logic [1:0] flag_op = '0;
  logic [2:0] flag_sel = '0;
  logic [7:0] acc_out, status_out;
  logic flag_bit;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  adc_flag_unit dut (.*);

  localparam int NV = 8;
  // {A, M, carry_in, expected result, expected {N,V,Z,C}}
  localparam logic [28:0] VEC [NV] = '{
    {8'h50, 8'h50, 1'b0, 8'hA0, 4'b1100},
    {8'hFF, 8'h01, 1'b0, 8'h00, 4'b0011},
    {8'h80, 8'h80, 1'b0, 8'h00, 4'b0111},
    {8'h7F, 8'h00, 1'b1, 8'h80, 4'b1100},
    {8'h12, 8'h34, 1'b1, 8'h47, 4'b0000},
    {8'hFF, 8'hFF, 1'b1, 8'hFF, 4'b1001},
    {8'hD0, 8'h90, 1'b0, 8'h60, 4'b0101},
    {8'h00, 8'h00, 1'b0, 8'h00, 4'b0010}
  };

  task automatic cyc();
    @(posedge clk); #1;
    ld_en = 0; add_en = 0; st_wr_en = 0; flag_op = 2'b00;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_st(input logic [7:0] v);
    st_wr_en = 1; st_wr_data = v; cyc();
  endtask
  task automatic load(input logic [7:0] v);
    ld_en = 1; ld_data = v; cyc();
  endtask
  task automatic fop(input logic [1:0] op, input logic [2:0] sel);
    flag_op = op; flag_sel = sel; cyc();
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(); cyc();
    rst = 0;
    chk("R1 acc", acc_out, 8'h00);
    chk("R1 status", status_out, 8'h20);

    for (int i = 0; i < NV; i++) begin
      wr_st(8'h20);
      load(VEC[i][28:21]);
      if (VEC[i][12]) fop(2'b01, 3'd0);
      add_en = 1; operand = VEC[i][20:13]; cyc();
      chk($sformatf("R3 acc vec%0d", i), acc_out, VEC[i][11:4]);
      chk($sformatf("R4 R5 NVZC vec%0d", i), {4'd0, status_out[7], status_out[6], status_out[1], status_out[0]}, {4'd0, VEC[i][3:0]});
    end

    // R6: load after 0x80+0x80 keeps C and V, updates Z and N
    wr_st(8'h20); load(8'h80); add_en = 1; operand = 8'h80; cyc();
    chk("R6 pre", status_out, 8'h63);
    load(8'h80);
    chk("R6 load acc", acc_out, 8'h80);
    chk("R6 load flags", status_out, 8'hE1);
    load(8'h00);
    chk("R5 load zero", status_out, 8'h63);

    // R7: add wins over load
    wr_st(8'h20); load(8'h10);
    add_en = 1; operand = 8'h01; ld_en = 1; ld_data = 8'h99; cyc();
    chk("R7 acc", acc_out, 8'h11);
    chk("R7 status", status_out, 8'h20);

    // R8: add keeps I, D, B
    wr_st(8'h3C); load(8'h01);
    add_en = 1; operand = 8'h02; cyc();
    chk("R8 acc", acc_out, 8'h03);
    chk("R8 status", status_out, 8'h3C);

    // R9, R11: single-flag set, clear, test
    wr_st(8'h00);
    chk("R2 write zero", status_out, 8'h20);
    fop(2'b01, 3'd2); chk("R9 set I", status_out, 8'h24);
    fop(2'b01, 3'd7); chk("R9 set N", status_out, 8'hA4);
    fop(2'b10, 3'd2); chk("R9 clear I", status_out, 8'hA0);
    fop(2'b10, 3'd5); chk("R2 clear reserved", status_out, 8'hA0);
    fop(2'b11, 3'd0); chk("R9 code 11 no-op", status_out, 8'hA0);
    flag_sel = 3'd7; #1; chk("R11 test N", {7'd0, flag_bit}, 8'd1);
    flag_sel = 3'd2; #1; chk("R11 test I", {7'd0, flag_bit}, 8'd0);

    // R9: set overrides add flags, acc still written
    wr_st(8'h20); load(8'h05);
    add_en = 1; operand = 8'h01; flag_op = 2'b01; flag_sel = 3'd0; cyc();
    chk("R9 set with add acc", acc_out, 8'h06);
    chk("R9 set with add status", status_out, 8'h21);

    // R10: byte write
    wr_st(8'hFF); chk("R10 write FF", status_out, 8'hFF);
    st_wr_en = 1; st_wr_data = 8'h01; flag_op = 2'b01; flag_sel = 3'd7; cyc();
    chk("R10 write beats set", status_out, 8'h21);

    // R1: reset again
    rst = 1; cyc(); rst = 0;
    chk("R1 acc again", acc_out, 8'h00);
    chk("R1 status again", status_out, 8'h20);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule